// File: doc/BRIEF.md
# Packed-Load Interpolating Transfer Curve Table

This block applies a per-channel transfer curve to a three-channel pixel stream, as the electro-optical or opto-electronic transfer stage of an overlay path. Each of the red, green and blue channels owns a curve of `ENTRIES` sample points. Each incoming channel value selects a segment of its curve, and the output is linearly interpolated between the two sample points that bound that segment.

Software fills the curves through a small write port. A write to the address register rewinds the load pointer. Each write to the data register then stores two 16-bit sample points and advances the pointer by two. The three curves sit back to back in one flat table, red first, then green, then blue. Because each curve has an odd length, one data word carries the last red point and the first green point. A control register holds a master enable and one enable per channel. A channel that is not enabled passes its input through unchanged. The table must not be loaded while pixels stream.

Top module: `xfer_lut`

## Requirements
- R1: After reset all outputs are 0, every table entry is 0, the load pointer is 0 and all enables are clear.
- R2: A write with `cfg_sel` = 0 (address register) returns the load pointer to entry 0, whatever the data value.
- R3: A write with `cfg_sel` = 1 (data register) stores `cfg_wdata[15:0]` at the pointer and `cfg_wdata[31:16]` at the pointer plus 1, then advances the pointer by 2.
- R4: Flat entry `c*ENTRIES + i` is point i of channel c (0 red, 1 green, 2 blue). So with 33 points, the low half of word 16 is red point 32 and the high half is green point 0. In word 49 only the low half, blue point 32, is kept.
- R5: Once all `3*ENTRIES` entries are written, the pointer stays at the end and further data writes change no entry.
- R6: For an enabled channel with 12-bit input x, the segment is s = x[11:7] and the fraction is f = x[6:0]. The output is (P[s]*(128-f) + P[s+1]*f) >> 7, where P is that channel's curve.
- R7: A write with `cfg_sel` = 2 loads the control register. Bit 31 is the master enable; bits 27, 28 and 29 enable red, green and blue. A channel is interpolated only when the master bit and its own bit are both set. Otherwise its output is its input, zero-extended to 16 bits. Writes with `cfg_sel` = 3 do nothing.
- R8: An input sampled on clock edge k appears at the output after edge k+1. A control write taking effect on edge k governs the pixels sampled on edge k+1 and later.
- R9: A curve whose point i equals i*512 maps every input x to exactly 4*x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| cfg_wdata | input | 32 | Configuration write data |
| pix_r_i | input | IN_W | Red channel input |
| pix_g_i | input | IN_W | Green channel input |
| pix_b_i | input | IN_W | Blue channel input |
| pix_r_o | output | ENTRY_W | Red channel output |
| pix_g_o | output | ENTRY_W | Green channel output |
| pix_b_o | output | ENTRY_W | Blue channel output |

## Verification
The bench builds the block with its defaults: 33 points per curve, 16-bit points and 12-bit inputs. This gives 32 segments of 128 steps each and a 99-entry flat table loaded in 50 words. With these values the bench reaches the word shared by red and green, the half-empty final word, and writes past the end. It also reaches the top segment, where input 4095 weights the last blue point by 127/128, and segment boundaries where the fraction is zero.

// File: rtl/xlut_pkg.sv
package xlut_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  localparam int CTRL_EN_LSB = 27;
  localparam int CTRL_MASTER = 31;
  localparam int NUM_CH      = 3;
endpackage

// File: rtl/xlut_cfg.sv
module xlut_cfg
  import xlut_pkg::*;
#(
  parameter int ENTRIES = 33,
  parameter int ENTRY_W = 16,
  localparam int TOTAL  = NUM_CH * ENTRIES,
  localparam int PTR_W  = $clog2(TOTAL + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [1:0]                         cfg_sel,
  input  logic [31:0]                        cfg_wdata,
  output logic [TOTAL-1:0][ENTRY_W-1:0]      tbl_o,
  output logic [PTR_W-1:0]                   ptr_o,
  output logic [NUM_CH-1:0]                  chan_on_o
);
  logic             addr_we, data_we, ctrl_we;
  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic [PTR_W:0]   ptr_sum, ptr_plus1;
  logic [NUM_CH-1:0] en_q, en_nxt;
  logic             master_q, master_nxt;

  always_comb begin
    addr_we    = cfg_we && (cfg_sel == SEL_ADDR);
    data_we    = cfg_we && (cfg_sel == SEL_DATA);
    ctrl_we    = cfg_we && (cfg_sel == SEL_CTRL);
    ptr_plus1  = {1'b0, ptr_q} + (PTR_W+1)'(1);
    ptr_sum    = {1'b0, ptr_q} + (PTR_W+1)'(2);
    ptr_nxt    = ptr_q;
    if (addr_we) begin
      ptr_nxt = '0;
    end else if (data_we) begin
      if (ptr_sum > (PTR_W+1)'(TOTAL)) ptr_nxt = PTR_W'(TOTAL);
      else                             ptr_nxt = ptr_sum[PTR_W-1:0];
    end
    en_nxt     = ctrl_we ? cfg_wdata[CTRL_EN_LSB +: NUM_CH] : en_q;
    master_nxt = ctrl_we ? cfg_wdata[CTRL_MASTER] : master_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      en_q     <= '0;
      master_q <= 1'b0;
    end else begin
      ptr_q    <= ptr_nxt;
      en_q     <= en_nxt;
      master_q <= master_nxt;
    end
  end

  for (genvar i = 0; i < TOTAL; i++) begin : g_entry
    logic lo_hit, hi_hit;
    logic [ENTRY_W-1:0] ent_q;
    assign lo_hit = data_we && (ptr_q == PTR_W'(i));
    assign hi_hit = data_we && (ptr_plus1 == (PTR_W+1)'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (lo_hit) ent_q <= cfg_wdata[ENTRY_W-1:0];
      else if (hi_hit) ent_q <= cfg_wdata[16 +: ENTRY_W];
    end
    assign tbl_o[i] = ent_q;
  end

  assign ptr_o     = ptr_q;
  assign chan_on_o = en_q & {NUM_CH{master_q}};
endmodule

// File: rtl/xlut_chan.sv
module xlut_chan #(
  parameter int ENTRIES = 33,
  parameter int ENTRY_W = 16,
  parameter int IN_W    = 12,
  localparam int SEG_W  = $clog2(ENTRIES - 1),
  localparam int FRAC_W = IN_W - SEG_W,
  localparam int ACC_W  = ENTRY_W + FRAC_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          on_i,
  input  logic [ENTRIES-1:0][ENTRY_W-1:0] curve_i,
  input  logic [IN_W-1:0]               pix_i,
  output logic [ENTRY_W-1:0]            pix_o
);
  logic [SEG_W-1:0]   seg;
  logic [SEG_W:0]     seg_hi;
  logic [ENTRY_W-1:0] lo_q, hi_q, out_q, out_nxt;
  logic [FRAC_W-1:0]  frac_q;
  logic [IN_W-1:0]    raw_q;
  logic               on_q;
  logic [FRAC_W:0]    w_lo, w_hi;
  logic [ACC_W-1:0]   acc;

  assign seg    = pix_i[IN_W-1 -: SEG_W];
  assign seg_hi = {1'b0, seg} + (SEG_W+1)'(1);

  // stage 1: fetch bounding points, keep fraction and raw input
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      frac_q <= '0;
      raw_q  <= '0;
      on_q   <= 1'b0;
    end else begin
      lo_q   <= curve_i[seg];
      hi_q   <= curve_i[seg_hi];
      frac_q <= pix_i[FRAC_W-1:0];
      raw_q  <= pix_i;
      on_q   <= on_i;
    end
  end

  // stage 2: weighted blend of the two points
  always_comb begin
    w_hi    = {1'b0, frac_q};
    w_lo    = (FRAC_W+1)'(1 << FRAC_W) - w_hi;
    acc     = ACC_W'(lo_q) * ACC_W'(w_lo) + ACC_W'(hi_q) * ACC_W'(w_hi);
    out_nxt = on_q ? acc[FRAC_W +: ENTRY_W] : ENTRY_W'(raw_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_nxt;
  end

  assign pix_o = out_q;
endmodule

// File: rtl/xfer_lut.sv
module xfer_lut
  import xlut_pkg::*;
#(
  parameter int ENTRIES = 33,
  parameter int ENTRY_W = 16,
  parameter int IN_W    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  input  logic [IN_W-1:0]    pix_r_i,
  input  logic [IN_W-1:0]    pix_g_i,
  input  logic [IN_W-1:0]    pix_b_i,
  output logic [ENTRY_W-1:0] pix_r_o,
  output logic [ENTRY_W-1:0] pix_g_o,
  output logic [ENTRY_W-1:0] pix_b_o
);
  localparam int TOTAL = NUM_CH * ENTRIES;
  localparam int PTR_W = $clog2(TOTAL + 1);

  logic [TOTAL-1:0][ENTRY_W-1:0] tbl;
  logic [PTR_W-1:0]              load_ptr;
  logic [NUM_CH-1:0]             chan_on;
  logic [NUM_CH-1:0][IN_W-1:0]    pix_in;
  logic [NUM_CH-1:0][ENTRY_W-1:0] pix_out;

  assign pix_in = {pix_b_i, pix_g_i, pix_r_i};

  xlut_cfg #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W)) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .tbl_o     (tbl),
    .ptr_o     (load_ptr),
    .chan_on_o (chan_on)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    xlut_chan #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W), .IN_W(IN_W)) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .on_i    (chan_on[c]),
      .curve_i (tbl[c*ENTRIES +: ENTRIES]),
      .pix_i   (pix_in[c]),
      .pix_o   (pix_out[c])
    );
  end

  assign pix_r_o = pix_out[0];
  assign pix_g_o = pix_out[1];
  assign pix_b_o = pix_out[2];
endmodule

// File: rtl/xfer_lut_chk.sv
module xfer_lut_chk #(
  parameter int TOTAL   = 99,
  parameter int PTR_W   = 7,
  parameter int IN_W    = 12,
  parameter int ENTRY_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [1:0]         cfg_sel,
  input logic [PTR_W-1:0]   ptr,
  input logic [2:0]         chan_on,
  input logic [IN_W-1:0]    pix_r_i,
  input logic [ENTRY_W-1:0] pix_r_o
);
  assert_addr_rewind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd0) |=> (ptr == '0));

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd1 && ptr <= PTR_W'(TOTAL - 2)) |=> (ptr == $past(ptr) + PTR_W'(2)));

  assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd1 && ptr == PTR_W'(TOTAL)) |=> (ptr == PTR_W'(TOTAL)));

  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(TOTAL));

  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(chan_on[0], 2) |-> (pix_r_o == ENTRY_W'($past(pix_r_i, 2))));
endmodule

bind xfer_lut xfer_lut_chk #(.TOTAL(TOTAL), .PTR_W(PTR_W), .IN_W(IN_W), .ENTRY_W(ENTRY_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_we  (cfg_we),
  .cfg_sel (cfg_sel),
  .ptr     (load_ptr),
  .chan_on (chan_on),
  .pix_r_i (pix_r_i),
  .pix_r_o (pix_r_o)
);

// File: tb/xfer_lut_tb.sv
`timescale 1ns/1ps
module xfer_lut_tb_top;
  localparam int NP = 33;
  localparam int NT = 3 * NP;

  logic        clk, rst_n, cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [11:0] pr, pg, pb;
  logic [15:0] qr, qg, qb;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit cmp_on = 0;

  int mt[NT];
  int mptr;
  bit men[3];
  bit mmaster;
  int e1[3], e2[3];

  xfer_lut dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pix_r_i(pr), .pix_g_i(pg), .pix_b_i(pb),
    .pix_r_o(qr), .pix_g_o(qg), .pix_b_o(qb)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic int model_out(int c, int x);
    int s, f;
    if (!(mmaster && men[c])) return x;
    s = x / 128;
    f = x % 128;
    return (mt[c*NP+s] * (128 - f) + mt[c*NP+s+1] * f) / 128;
  endfunction

  function automatic int in_of(int c);
    return (c == 0) ? int'(pr) : (c == 1) ? int'(pg) : int'(pb);
  endfunction

  function automatic int out_of(int c);
    return (c == 0) ? int'(qr) : (c == 1) ? int'(qg) : int'(qb);
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) mt[i] = 0;
      mptr = 0; mmaster = 0;
      for (int c = 0; c < 3; c++) begin men[c] = 0; e1[c] = 0; e2[c] = 0; end
    end else begin
      for (int c = 0; c < 3; c++) begin
        e2[c] = e1[c];
        e1[c] = model_out(c, in_of(c));
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: mptr = 0;
          2'd1: begin
            if (mptr < NT) mt[mptr] = int'(cfg_wdata[15:0]);
            if (mptr + 1 < NT) mt[mptr+1] = int'(cfg_wdata[31:16]);
            mptr = (mptr + 2 > NT) ? NT : mptr + 2;
          end
          2'd2: begin
            mmaster = cfg_wdata[31];
            for (int c = 0; c < 3; c++) men[c] = cfg_wdata[27+c];
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on)
      for (int c = 0; c < 3; c++) check({phase, " per-cycle"}, out_of(c), e2[c]);
  end

  task automatic cfg_write(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pix(int r, int g, int b);
    @(negedge clk);
    pr = 12'(r); pg = 12'(g); pb = 12'(b);
  endtask

  // hold one pixel and check the output two edges later
  task automatic pix_check(string tag, int r, int g, int b, int er, int eg, int eb);
    pix(r, g, b);
    @(negedge clk);
    @(negedge clk);
    check(tag, int'(qr), er);
    check(tag, int'(qg), eg);
    check(tag, int'(qb), eb);
  endtask

  task automatic load_curves(int kind);
    int flat[NT];
    for (int i = 0; i < NP; i++) begin
      if (kind == 0) begin
        flat[i] = i * 512; flat[NP+i] = i * 512; flat[2*NP+i] = i * 512;
      end else begin
        flat[i] = i * 100; flat[NP+i] = 3000 - i * 50; flat[2*NP+i] = i * i * 60;
      end
    end
    cfg_write(2'd0, 32'd0);
    for (int w = 0; w < (NT + 1) / 2; w++) begin
      logic [15:0] hi;
      hi = (2*w + 1 < NT) ? 16'(flat[2*w+1]) : 16'h0;
      cfg_write(2'd1, {hi, 16'(flat[2*w])});
    end
  endtask

  task automatic random_pixels(int n);
    for (int k = 0; k < n; k++) pix($urandom % 4096, $urandom % 4096, $urandom % 4096);
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; pr = 0; pg = 0; pb = 0;
    repeat (3) @(negedge clk);
    check("R1 reset out r", int'(qr), 0);
    check("R1 reset out g", int'(qg), 0);
    check("R1 reset out b", int'(qb), 0);
    rst_n = 1;
    cmp_on = 1;

    // R7 bypass with everything clear
    phase = "R7";
    pix_check("R7 bypass", 4095, 1, 2048, 4095, 1, 2048);
    random_pixels(20);

    // R1 zero table with all enabled
    phase = "R1";
    cfg_write(2'd2, 32'hB800_0000);
    pix_check("R1 zero table", 4095, 1234, 77, 0, 0, 0);

    // R9 linear curve
    phase = "R9";
    load_curves(0);
    pix_check("R9 linear", 4095, 129, 0, 16380, 516, 0);
    pix_check("R9 linear", 1000, 2047, 3333, 4000, 8188, 13332);
    random_pixels(30);

    // R8 latency
    phase = "R8";
    pix(100, 100, 100);
    @(negedge clk); @(negedge clk);
    pix(200, 300, 400);
    @(negedge clk);
    check("R8 latency old r", int'(qr), 400);
    @(negedge clk);
    check("R8 latency new r", int'(qr), 800);
    check("R8 latency new b", int'(qb), 1600);

    // R4 distinct curves, straddling word
    phase = "R4";
    load_curves(1);
    pix_check("R4 channel order", 4095, 0, 4095, 3199, 3000, 61410);
    pix_check("R4 segment edge", 128, 4095, 0, 100, 1400, 0);

    // R6 interpolation at mixed patterns
    phase = "R6";
    pix_check("R6 blend", 64, 192, 200, 50, 2925, 60 + (240 - 60) * 72 / 128);
    random_pixels(40);

    // R7 mixed enables
    phase = "R7";
    cfg_write(2'd2, 32'h2800_0000);
    pix_check("R7 no master", 300, 301, 302, 300, 301, 302);
    cfg_write(2'd2, 32'hA800_0000);
    pix_check("R7 red+blue", 128, 777, 128, 100, 777, 60);
    cfg_write(2'd3, 32'h0000_0000);
    pix_check("R7 sel3 ignored", 128, 777, 128, 100, 777, 60);
    random_pixels(20);

    // R5 writes past the end
    phase = "R5";
    cfg_write(2'd2, 32'hB800_0000);
    for (int k = 0; k < 3; k++) cfg_write(2'd1, 32'hFFFF_FFFF);
    pix_check("R5 overflow ignored", 4095, 0, 4095, 3199, 3000, 61410);

    // R2 rewind with nonzero value, then R3 single word
    phase = "R2";
    cfg_write(2'd0, 32'd5);
    cfg_write(2'd1, 32'h1234_5678);
    pix_check("R2 R3 low half", 0, 0, 0, 32'h5678, 3000, 0);
    pix_check("R3 high half", 128, 0, 0, 32'h1234, 3000, 0);
    pix_check("R3 midpoint", 64, 0, 0, 13398, 3000, 0);
    phase = "R3";
    random_pixels(20);
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule